// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a small array of machine-check banks, each holding a control word, a status word, an address and a misc word. Three global registers sit beside them: a capability word, a global control word and a global status word. An error source presents one injection request at a time. The request carries a bank index, a bank status word, a global status word, an address, a misc value and an unconditional flag. The block checks the request against the capability word and the bank count, and applies the in-progress and reporting-enable rules. It then logs the error into the bank, merges it as an overflow, drops it, or escalates it.

The outcome of each request is reported with a one-cycle done pulse and a 3-bit reason code. A logged uncorrected error also raises a one-cycle machine-check interrupt pulse. An uncorrected error that cannot be delivered raises a one-cycle system reset request instead. A plain write port and a combinational read port give direct access to every register. The machine-check enable comes from a processor control bit through `mc_enable_i`.

Top module: `mc_bank_logger`

## Requirements
- R1: After reset `ready_o` is 1, and `done_o`, `mc_irq_o` and `reset_req_o` are 0. The global status and all bank registers read 0, and the capability word reads NUM_BANKS in bits [7:0] with bit 8 (control-present) set, i.e. 0x104 for 4 banks.
- R2: A request is taken on a clock edge where `inj_valid_i` and `ready_o` are both 1. `ready_o` is 0 for the next cycle. `done_o` is high for exactly one cycle after the second edge following acceptance, and at that point `ready_o` is 1 again.
- R3: `reason_o` is valid while `done_o` is high, with these codes: 0 logged, 1 injection unsupported, 2 bad bank index, 3 status not valid, 4 dropped while in progress, 5 uncorrected reporting disabled, 6 escalated to reset, 7 corrected error kept out by an uncorrected entry (overflow marked).
- R4: Requests are rejected in this order. A capability word of zero gives 1. A bank index at or above capability bits [7:0], or at or above NUM_BANKS, gives 2. Status bit 63 (valid) clear gives 3. A rejected request changes no register.
- R5: If global status bit 2 (in progress) is set, status bit 55 (action required) is clear and the unconditional flag is low, the request gives 4 and the bank is unchanged.
- R6: An uncorrected request (status bit 61) gives 5 and changes nothing when either of two conditions holds. The first is that capability bit 8 is set and the global control word is not all ones. The second is that the bank control word is not all ones.
- R7: An uncorrected request that passes R6 while global status bit 2 is set or `mc_enable_i` is low gives 6. It pulses `reset_req_o` together with `done_o` and logs nothing.
- R8: Otherwise an uncorrected request writes the bank status with bit 62 (overflow) added if the bank already held a valid entry. It also writes the bank address and misc words, loads the global status from the request, gives 0 and pulses `mc_irq_o` together with `done_o`.
- R9: A corrected request into an empty bank, or into a bank holding a corrected entry, overwrites status, address and misc. It adds overflow if the bank was valid, gives 0, raises no interrupt and leaves the global status alone.
- R10: A corrected request into a bank holding a valid uncorrected entry only sets overflow in the existing status, keeps address and misc, and gives 7.
- R11: The write port stores `wr_data_i` into the register picked by `wr_sel_i` and `wr_bank_i`, with these select codes: 0 capability, 1 global control, 2 global status, 3 bank control, 4 bank status, 5 bank address, 6 bank misc. `rd_data_o` shows the register picked by `rd_sel_i`/`rd_bank_i` in the same cycle. When the logger and the write port update the same register on one edge, the logger's value is kept.
- R12: `mc_irq_o` and `reset_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inj_valid_i | input | 1 | Injection request present |
| ready_o | output | 1 | Logger can take a request |
| inj_bank_i | input | 8 | Target bank index |
| inj_status_i | input | 64 | Bank status word to log |
| inj_gstat_i | input | 64 | Global status word to load |
| inj_addr_i | input | 64 | Error address |
| inj_misc_i | input | 64 | Error misc information |
| inj_uncond_i | input | 1 | Bypass the in-progress drop rule |
| mc_enable_i | input | 1 | Machine-check delivery enabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for write |
| wr_bank_i | input | 8 | Bank index for write |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 3 | Register select for read |
| rd_bank_i | input | 8 | Bank index for read |
| rd_data_o | output | 64 | Read data |
| done_o | output | 1 | One-cycle request completion |
| reason_o | output | 3 | Outcome code |
| mc_irq_o | output | 1 | Machine-check interrupt pulse |
| reset_req_o | output | 1 | System reset request pulse |

## Verification
A software write and a logger update can land on the same bank register on the same edge. The bench provokes this by issuing a bank-status write in the evaluation cycle of an accepted request to that bank. It then reads the status back and expects the logger's value with overflow merged, not the written pattern. The escalation and interrupt outputs are also checked cycle by cycle against the done pulse, so that no outcome lets both pulses rise together.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DW        = 64;
  localparam int BIDX_W    = 8;
  localparam int ST_VAL    = 63;
  localparam int ST_OVER   = 62;
  localparam int ST_UC     = 61;
  localparam int ST_AR     = 55;
  localparam int GS_INPROG = 2;
  localparam int CAP_CTLP  = 8;

  typedef enum logic [2:0] {
    RSN_OK     = 3'd0,
    RSN_UNSUP  = 3'd1,
    RSN_BANK   = 3'd2,
    RSN_STAT   = 3'd3,
    RSN_DROP   = 3'd4,
    RSN_MASKED = 3'd5,
    RSN_ESCAL  = 3'd6,
    RSN_KEPT   = 3'd7
  } reason_e;

  typedef enum logic [2:0] {
    SEL_CAP   = 3'd0,
    SEL_GCTL  = 3'd1,
    SEL_GSTAT = 3'd2,
    SEL_BCTL  = 3'd3,
    SEL_BSTAT = 3'd4,
    SEL_BADDR = 3'd5,
    SEL_BMISC = 3'd6
  } sel_e;

  typedef struct packed {
    logic [BIDX_W-1:0] bank;
    logic [DW-1:0]     status;
    logic [DW-1:0]     gstat;
    logic [DW-1:0]     addr;
    logic [DW-1:0]     misc;
    logic              uncond;
  } req_t;

  typedef struct packed {
    logic          wr_stat;
    logic          wr_am;
    logic          wr_gstat;
    logic          irq;
    logic          rst;
    logic [DW-1:0] new_stat;
    reason_e       reason;
  } act_t;
endpackage

// File: rtl/mcb_globals.sv
module mcb_globals
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int CAP_CTLP_RST = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_we_i,
  input  logic [2:0]    sw_sel_i,
  input  logic [DW-1:0] sw_data_i,
  input  logic          log_gstat_we_i,
  input  logic [DW-1:0] log_gstat_i,
  output logic [DW-1:0] cap_o,
  output logic [DW-1:0] gctl_o,
  output logic [DW-1:0] gstat_o
);
  localparam logic [DW-1:0] CAP_RST =
    DW'(NUM_BANKS) | (DW'(CAP_CTLP_RST) << CAP_CTLP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o   <= CAP_RST;
      gctl_o  <= '0;
      gstat_o <= '0;
    end else begin
      if (sw_we_i && sw_sel_i == SEL_CAP)  cap_o  <= sw_data_i;
      if (sw_we_i && sw_sel_i == SEL_GCTL) gctl_o <= sw_data_i;
      // logger update wins over a same-edge software write
      if (log_gstat_we_i)                          gstat_o <= log_gstat_i;
      else if (sw_we_i && sw_sel_i == SEL_GSTAT)   gstat_o <= sw_data_i;
    end
  end
endmodule

// File: rtl/mcb_bank_array.sv
module mcb_bank_array
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [2:0]        sw_sel_i,
  input  logic [BIDX_W-1:0] sw_bank_i,
  input  logic [DW-1:0]     sw_data_i,
  input  logic [BIDX_W-1:0] log_bank_i,
  input  logic              log_stat_we_i,
  input  logic [DW-1:0]     log_stat_i,
  input  logic              log_am_we_i,
  input  logic [DW-1:0]     log_addr_i,
  input  logic [DW-1:0]     log_misc_i,
  output logic [DW-1:0]     ctl_o  [NUM_BANKS],
  output logic [DW-1:0]     stat_o [NUM_BANKS],
  output logic [DW-1:0]     addr_o [NUM_BANKS],
  output logic [DW-1:0]     misc_o [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sw_hit, log_hit;
    assign sw_hit  = sw_we_i && (int'(sw_bank_i) == b);
    assign log_hit = (int'(log_bank_i) == b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[b]  <= '0;
        stat_o[b] <= '0;
        addr_o[b] <= '0;
        misc_o[b] <= '0;
      end else begin
        if (sw_hit && sw_sel_i == SEL_BCTL) ctl_o[b] <= sw_data_i;

        if (log_hit && log_stat_we_i)              stat_o[b] <= log_stat_i;
        else if (sw_hit && sw_sel_i == SEL_BSTAT)  stat_o[b] <= sw_data_i;

        if (log_hit && log_am_we_i)                addr_o[b] <= log_addr_i;
        else if (sw_hit && sw_sel_i == SEL_BADDR)  addr_o[b] <= sw_data_i;

        if (log_hit && log_am_we_i)                misc_o[b] <= log_misc_i;
        else if (sw_hit && sw_sel_i == SEL_BMISC)  misc_o[b] <= sw_data_i;
      end
    end
  end
endmodule

// File: rtl/mcb_classify.sv
module mcb_classify
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  req_t          req_i,
  input  logic [DW-1:0] cap_i,
  input  logic [DW-1:0] gctl_i,
  input  logic [DW-1:0] gstat_i,
  input  logic [DW-1:0] bctl_i,
  input  logic [DW-1:0] bstat_i,
  input  logic          mc_en_i,
  output act_t          act_o
);
  localparam logic [DW-1:0] OVER_M = DW'(1) << ST_OVER;

  logic [DW-1:0] over_if_valid;
  logic          uc_masked;

  assign over_if_valid = bstat_i[ST_VAL] ? OVER_M : '0;
  assign uc_masked     = (cap_i[CAP_CTLP] && (gctl_i != '1)) || (bctl_i != '1);

  always_comb begin
    act_o        = '0;
    act_o.reason = RSN_OK;
    if (cap_i == '0) begin
      act_o.reason = RSN_UNSUP;
    end else if ((req_i.bank >= cap_i[BIDX_W-1:0]) || (int'(req_i.bank) >= NUM_BANKS)) begin
      act_o.reason = RSN_BANK;
    end else if (!req_i.status[ST_VAL]) begin
      act_o.reason = RSN_STAT;
    end else if (!req_i.uncond && !req_i.status[ST_AR] && gstat_i[GS_INPROG]) begin
      act_o.reason = RSN_DROP;
    end else if (req_i.status[ST_UC]) begin
      if (uc_masked) begin
        act_o.reason = RSN_MASKED;
      end else if (gstat_i[GS_INPROG] || !mc_en_i) begin
        act_o.reason = RSN_ESCAL;
        act_o.rst    = 1'b1;
      end else begin
        act_o.wr_stat  = 1'b1;
        act_o.wr_am    = 1'b1;
        act_o.wr_gstat = 1'b1;
        act_o.irq      = 1'b1;
        act_o.new_stat = req_i.status | over_if_valid;
      end
    end else if (!bstat_i[ST_VAL] || !bstat_i[ST_UC]) begin
      act_o.wr_stat  = 1'b1;
      act_o.wr_am    = 1'b1;
      act_o.new_stat = req_i.status | over_if_valid;
    end else begin
      // keep the uncorrected entry, only flag the lost event
      act_o.reason   = RSN_KEPT;
      act_o.wr_stat  = 1'b1;
      act_o.new_stat = bstat_i | OVER_M;
    end
  end
endmodule

// File: rtl/mc_bank_logger.sv
module mc_bank_logger
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int CAP_CTLP_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inj_valid_i,
  output logic              ready_o,
  input  logic [BIDX_W-1:0] inj_bank_i,
  input  logic [DW-1:0]     inj_status_i,
  input  logic [DW-1:0]     inj_gstat_i,
  input  logic [DW-1:0]     inj_addr_i,
  input  logic [DW-1:0]     inj_misc_i,
  input  logic              inj_uncond_i,
  input  logic              mc_enable_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [BIDX_W-1:0] wr_bank_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [2:0]        rd_sel_i,
  input  logic [BIDX_W-1:0] rd_bank_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              done_o,
  output logic [2:0]        reason_o,
  output logic              mc_irq_o,
  output logic              reset_req_o
);
  logic          busy_q;
  req_t          req_q;
  act_t          act;
  logic          accept;
  logic [DW-1:0] cap, gctl, gstat;
  logic [DW-1:0] b_ctl  [NUM_BANKS];
  logic [DW-1:0] b_stat [NUM_BANKS];
  logic [DW-1:0] b_addr [NUM_BANKS];
  logic [DW-1:0] b_misc [NUM_BANKS];
  logic [DW-1:0] sel_ctl, sel_stat;
  logic [DW-1:0] rd_ctl, rd_stat, rd_addr, rd_misc;

  assign ready_o = !busy_q;
  assign accept  = inj_valid_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      req_q       <= '0;
      done_o      <= 1'b0;
      reason_o    <= 3'd0;
      mc_irq_o    <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      done_o      <= busy_q;
      mc_irq_o    <= busy_q && act.irq;
      reset_req_o <= busy_q && act.rst;
      if (busy_q) reason_o <= act.reason;
      if (accept) begin
        busy_q <= 1'b1;
        req_q  <= '{bank: inj_bank_i, status: inj_status_i, gstat: inj_gstat_i,
                    addr: inj_addr_i, misc: inj_misc_i, uncond: inj_uncond_i};
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  // bank views for the request and for the read port
  always_comb begin
    sel_ctl  = '0;
    sel_stat = '0;
    rd_ctl   = '0;
    rd_stat  = '0;
    rd_addr  = '0;
    rd_misc  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(req_q.bank) == b) begin
        sel_ctl  = b_ctl[b];
        sel_stat = b_stat[b];
      end
      if (int'(rd_bank_i) == b) begin
        rd_ctl  = b_ctl[b];
        rd_stat = b_stat[b];
        rd_addr = b_addr[b];
        rd_misc = b_misc[b];
      end
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_CAP:   rd_data_o = cap;
      SEL_GCTL:  rd_data_o = gctl;
      SEL_GSTAT: rd_data_o = gstat;
      SEL_BCTL:  rd_data_o = rd_ctl;
      SEL_BSTAT: rd_data_o = rd_stat;
      SEL_BADDR: rd_data_o = rd_addr;
      SEL_BMISC: rd_data_o = rd_misc;
      default:   rd_data_o = '0;
    endcase
  end

  mcb_classify #(.NUM_BANKS(NUM_BANKS)) u_classify (
    .req_i   (req_q),
    .cap_i   (cap),
    .gctl_i  (gctl),
    .gstat_i (gstat),
    .bctl_i  (sel_ctl),
    .bstat_i (sel_stat),
    .mc_en_i (mc_enable_i),
    .act_o   (act)
  );

  mcb_globals #(.NUM_BANKS(NUM_BANKS), .CAP_CTLP_RST(CAP_CTLP_RST)) u_globals (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sw_we_i        (wr_en_i),
    .sw_sel_i       (wr_sel_i),
    .sw_data_i      (wr_data_i),
    .log_gstat_we_i (busy_q && act.wr_gstat),
    .log_gstat_i    (req_q.gstat),
    .cap_o          (cap),
    .gctl_o         (gctl),
    .gstat_o        (gstat)
  );

  mcb_bank_array #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sw_we_i       (wr_en_i),
    .sw_sel_i      (wr_sel_i),
    .sw_bank_i     (wr_bank_i),
    .sw_data_i     (wr_data_i),
    .log_bank_i    (req_q.bank),
    .log_stat_we_i (busy_q && act.wr_stat),
    .log_stat_i    (act.new_stat),
    .log_am_we_i   (busy_q && act.wr_am),
    .log_addr_i    (req_q.addr),
    .log_misc_i    (req_q.misc),
    .ctl_o         (b_ctl),
    .stat_o        (b_stat),
    .addr_o        (b_addr),
    .misc_o        (b_misc)
  );
endmodule

// File: rtl/mcb_sva.sv
module mcb_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       inj_valid_i,
  input logic       ready_o,
  input logic       done_o,
  input logic [2:0] reason_o,
  input logic       mc_irq_o,
  input logic       reset_req_o
);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && ready_o) |=> (!ready_o && !done_o));

  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (done_o && ready_o));

  assert_irq_on_log_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_irq_o |-> (done_o && reason_o == 3'd0));

  assert_reset_on_escal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (done_o && reason_o == 3'd6));

  assert_pulses_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mc_irq_o && reset_req_o));
endmodule

bind mc_bank_logger mcb_sva u_sva (.*);

// File: tb/mc_bank_logger_test.sv
`timescale 1ns/1ps
module mc_bank_logger_test;
  localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [7:0]  bank;
    logic [63:0] st;
    logic [63:0] gs;
    logic        unc;
    logic [2:0]  rsn;
    logic        irq;
    logic        rst;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'd0,   VAL | 64'h11,           64'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R9 empty bank
    '{8'd0,   VAL | 64'h22,           64'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R9 overwrite corrected
    '{8'd1,   VAL | UC | 64'h33,      64'd5, 1'b0, 3'd0, 1'b1, 1'b0}, // R8 log UC
    '{8'd1,   VAL | 64'h44,           64'd0, 1'b0, 3'd4, 1'b0, 1'b0}, // R5 drop
    '{8'd1,   VAL | 64'h44,           64'd0, 1'b1, 3'd7, 1'b0, 1'b0}, // R10 kept
    '{8'd2,   VAL | UC | AR | 64'h55, 64'd0, 1'b0, 3'd6, 1'b0, 1'b1}, // R7 in progress
    '{8'd3,   VAL | UC | AR | 64'h66, 64'd0, 1'b0, 3'd5, 1'b0, 1'b0}, // R6 bank ctl
    '{8'd4,   VAL | 64'h77,           64'd0, 1'b0, 3'd2, 1'b0, 1'b0}, // R4 bank count
    '{8'd0,   64'h88,                 64'd0, 1'b0, 3'd3, 1'b0, 1'b0}, // R4 not valid
    '{8'd200, VAL,                    64'd0, 1'b0, 3'd2, 1'b0, 1'b0}  // R4 far index
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inj_valid = 1'b0;
  logic        ready;
  logic [7:0]  inj_bank = '0;
  logic [63:0] inj_status = '0, inj_gstat = '0, inj_addr = '0, inj_misc = '0;
  logic        inj_uncond = 1'b0;
  logic        mc_enable = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_bank = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_bank = '0;
  logic [63:0] rd_data;
  logic        done;
  logic [2:0]  reason;
  logic        mc_irq;
  logic        reset_req;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mc_bank_logger uut (
    .clk_i(clk), .rst_ni(rst_n),
    .inj_valid_i(inj_valid), .ready_o(ready),
    .inj_bank_i(inj_bank), .inj_status_i(inj_status), .inj_gstat_i(inj_gstat),
    .inj_addr_i(inj_addr), .inj_misc_i(inj_misc), .inj_uncond_i(inj_uncond),
    .mc_enable_i(mc_enable),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_bank_i(wr_bank), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_bank_i(rd_bank), .rd_data_o(rd_data),
    .done_o(done), .reason_o(reason), .mc_irq_o(mc_irq), .reset_req_o(reset_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [7:0] bank, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_bank = bank; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sw_read(input logic [2:0] sel, input logic [7:0] bank, output logic [63:0] data);
    rd_sel = sel; rd_bank = bank;
    #0.5;
    data = rd_data;
  endtask

  // drives one request; samples busy in eval cycle and outcome after done edge
  task automatic inject(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                        input logic [63:0] ad, input logic [63:0] ms, input logic unc,
                        input bit collide, output logic busy_rdy, output logic [2:0] rsn,
                        output logic irq, output logic rst, output logic dn);
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = b; inj_status = st; inj_gstat = gs;
    inj_addr = ad; inj_misc = ms; inj_uncond = unc;
    @(negedge clk);
    inj_valid = 1'b0;
    busy_rdy = ready;
    if (collide) begin
      wr_en = 1'b1; wr_sel = 3'd4; wr_bank = b; wr_data = 64'hDEAD_BEEF;
    end
    @(negedge clk);
    wr_en = 1'b0;
    rsn = reason; irq = mc_irq; rst = reset_req; dn = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic br, ir, rr, dn;
    logic [2:0] rs;

    #12;
    check("R1 ready", 64'(ready), 64'd1);
    check("R1 done", 64'(done), 64'd0);
    check("R1 irq/rst", 64'({mc_irq, reset_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    sw_read(3'd0, 8'd0, d); check("R1 cap reset", d, 64'h104);
    sw_read(3'd2, 8'd0, d); check("R1 gstat reset", d, 64'd0);
    sw_read(3'd4, 8'd2, d); check("R1 bank status reset", d, 64'd0);

    sw_write(3'd1, 8'd0, ONES);
    for (int b = 0; b < 3; b++) sw_write(3'd3, 8'(b), ONES);
    sw_read(3'd1, 8'd0, d); check("R11 gctl readback", d, ONES);
    sw_read(3'd3, 8'd3, d); check("R11 bank3 ctl untouched", d, 64'd0);

    for (int i = 0; i < NV; i++) begin
      inject(VEC[i].bank, VEC[i].st, VEC[i].gs, 64'hA000 + 64'(i), 64'hB000 + 64'(i),
             VEC[i].unc, 1'b0, br, rs, ir, rr, dn);
      check($sformatf("R2 busy v%0d", i), 64'(br), 64'd0);
      check($sformatf("R2 done v%0d", i), 64'(dn), 64'd1);
      check($sformatf("R3 reason v%0d", i), 64'(rs), 64'(VEC[i].rsn));
      check($sformatf("R8 irq v%0d", i), 64'(ir), 64'(VEC[i].irq));
      check($sformatf("R7 reset v%0d", i), 64'(rr), 64'(VEC[i].rst));
      check($sformatf("R12 excl v%0d", i), 64'(ir && rr), 64'd0);
    end
    @(negedge clk);
    check("R2 done one cycle", 64'(done), 64'd0);
    check("R2 ready again", 64'(ready), 64'd1);

    sw_read(3'd4, 8'd0, d); check("R9 bank0 overflow merge", d, VAL | OVR | 64'h22);
    sw_read(3'd5, 8'd0, d); check("R9 bank0 addr", d, 64'hA001);
    sw_read(3'd4, 8'd1, d); check("R10 bank1 kept", d, VAL | UC | OVR | 64'h33);
    sw_read(3'd5, 8'd1, d); check("R10 bank1 addr kept", d, 64'hA002);
    sw_read(3'd6, 8'd1, d); check("R8 bank1 misc", d, 64'hB002);
    sw_read(3'd2, 8'd0, d); check("R8 gstat loaded", d, 64'd5);
    sw_read(3'd4, 8'd2, d); check("R7 bank2 untouched", d, 64'd0);
    sw_read(3'd4, 8'd3, d); check("R6 bank3 untouched", d, 64'd0);

    sw_write(3'd2, 8'd0, 64'd0);
    mc_enable = 1'b0;
    inject(8'd2, VAL | UC | 64'h99, 64'd1, 64'hC0, 64'hC1, 1'b0, 1'b0, br, rs, ir, rr, dn);
    check("R7 disabled reason", 64'(rs), 64'd6);
    check("R7 disabled reset pulse", 64'(rr), 64'd1);
    sw_read(3'd2, 8'd0, d); check("R7 gstat unchanged", d, 64'd0);
    mc_enable = 1'b1;
    inject(8'd2, VAL | UC | 64'h99, 64'd1, 64'hC0, 64'hC1, 1'b0, 1'b0, br, rs, ir, rr, dn);
    check("R8 reason", 64'(rs), 64'd0);
    check("R8 irq pulse", 64'(ir), 64'd1);
    sw_read(3'd4, 8'd2, d); check("R8 empty no overflow", d, VAL | UC | 64'h99);
    sw_read(3'd2, 8'd0, d); check("R8 gstat", d, 64'd1);

    inject(8'd0, VAL | 64'h5A, 64'd0, 64'hD0, 64'hD1, 1'b0, 1'b1, br, rs, ir, rr, dn);
    check("R11 collide reason", 64'(rs), 64'd0);
    sw_read(3'd4, 8'd0, d); check("R11 logger wins", d, VAL | OVR | 64'h5A);
    sw_read(3'd6, 8'd0, d); check("R9 misc written", d, 64'hD1);

    sw_write(3'd1, 8'd0, 64'hFFFF);
    inject(8'd0, VAL | UC | 64'h7, 64'd0, 64'hE0, 64'hE1, 1'b0, 1'b0, br, rs, ir, rr, dn);
    check("R6 gctl masked", 64'(rs), 64'd5);
    check("R6 no irq", 64'(ir), 64'd0);
    sw_write(3'd0, 8'd0, 64'h004);
    inject(8'd0, VAL | UC | 64'h7, 64'd0, 64'hE0, 64'hE1, 1'b0, 1'b0, br, rs, ir, rr, dn);
    check("R6 no ctl-present logs", 64'(rs), 64'd0);
    sw_read(3'd4, 8'd0, d); check("R8 overflow on valid", d, VAL | UC | OVR | 64'h7);

    sw_write(3'd0, 8'd0, 64'd0);
    inject(8'd0, VAL | 64'h1, 64'd0, 64'hF0, 64'hF1, 1'b0, 1'b0, br, rs, ir, rr, dn);
    check("R4 unsupported", 64'(rs), 64'd1);
    sw_read(3'd5, 8'd0, d); check("R4 addr untouched", d, 64'hE0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule